// File: doc/BRIEF.md
# Non-Posted Request Timeout and Configuration Retry Controller

This block sits beside the request engine of a PCIe-style requester and decides when an outbound non-posted request has to be given up. When a request is accepted, a response timer is started from a programmable count. If no completion comes back before the timer runs out, the block drops the request: it raises a one-cycle error pulse, reports the request as aborted and releases the requester.

Configuration requests get one more path. When such a request is answered with a configuration-retry status (CRS) and retry is enabled, the block waits a fixed number of timer ticks and then asks the requester to send the request again. It keeps doing this until a completion arrives or a second programmable window, opened by the first CRS, closes. Both timers advance on a shared tick, which comes from a free-running divide-by-8 prescaler.

Two 32-bit control words are written and read through a simple select/write port. Each word has a disable flag in bit 31 and a count in its low bits. All other bits are reserved.

Top module: `npr_timeout_ctrl`

## Requirements
- R1: After reset, the response-timer word reads 0x0010FFFF and the retry word reads 0x0400FFFF. In both words the disable flag (bit 31) is 0. Outputs `busy`, `done`, `tmo_err` and `reissue` are low.
- R2: With `reg_sel`=0, the word holds the response disable flag in bit 31 and the response count in bits 23:0. With `reg_sel`=1, it holds the retry disable flag in bit 31 and the retry count in bits 27:0. Writes update only these fields. Reserved bits always read 0.
- R3: One timer unit is 8 clock cycles. The timers advance only on clock edges whose index is a multiple of 8, where edge 1 is the first rising edge with reset released.
- R4: A request is accepted on an edge where `req_issue` is high while `busy` is low. With the response timer enabled and count N≥1, the block does the following on the Nth timer edge after acceptance: it pulses `done`, `aborted` and `tmo_err` together for one cycle, and `busy` falls.
- R5: A completion (`cpl_rcvd`) sampled while busy ends the request on that edge with `done`=1, `aborted`=0 and no `tmo_err`. This holds even when the response timer expires on the same edge.
- R6: When the response disable flag is 1, or the response count is 0, the request never times out. It stays busy until a completion arrives.
- R7: A CRS sampled for a configuration request with retry enabled starts a wait of REISSUE_GAP timer edges. At the end of the wait the block pulses `reissue` for one cycle, and the response timer restarts from the count captured at acceptance.
- R8: The retry window is loaded at acceptance and starts counting at the first CRS. On the Mth timer edge after that CRS, the request ends with `done`, `aborted` and `tmo_err`. If this edge coincides with the end of a reissue wait, no reissue is sent. A retry count of 0 never expires.
- R9: A CRS sampled for a non-configuration request, or with the retry disable flag set, never causes a reissue. The request ends on that edge as aborted with `tmo_err`.
- R10: A register write while a request is active changes nothing for that request. The new values apply from the next accepted request.
- R11: `req_issue` while `busy` is high is ignored, and the running timers are not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_issue | input | 1 | Strobe: a non-posted request has been sent |
| req_is_cfg | input | 1 | Qualifies `req_issue`: 1 for a configuration request |
| cpl_rcvd | input | 1 | Strobe: completion received for the active request |
| crs_rcvd | input | 1 | Strobe: configuration-retry status received |
| reg_wr | input | 1 | Write strobe for the selected control word |
| reg_sel | input | 1 | 0 selects the response word, 1 the retry word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of the selected word |
| busy | output | 1 | A request is being watched |
| reissue | output | 1 | One-cycle request to send the configuration request again |
| tmo_err | output | 1 | One-cycle error pulse on timeout or refused retry |
| done | output | 1 | One-cycle end-of-request indication |
| aborted | output | 1 | With `done`: 1 for aborted, 0 for success |

## Verification
Two pairs of events can land on the same clock edge. The first is a completion arriving on the very edge where the response timer expires. The bench provokes it by counting timer edges from acceptance and driving `cpl_rcvd` so that it is sampled exactly on the Nth tick edge; it then expects a clean success with no error. The second is the retry window closing on the same tick that ends a reissue wait. The retry sweep reaches it when the retry count equals the gap length, and it expects an abort with no reissue pulse. Every expected edge is computed arithmetically from the multiple-of-8 tick rule.

// File: rtl/nprt_pkg.sv
package nprt_pkg;

    // Watch state of the active request
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GAP  = 2'd2
    } nprt_state_e;

endpackage

// File: rtl/nprt_presc.sv
module nprt_presc #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        if (pre_q == PW'(DIV - 1)) pre_d = '0;
        else                       pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = (pre_q == PW'(DIV - 1));

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

endmodule

// File: rtl/nprt_tmr.sv
module nprt_tmr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                             cnt_d = load_val;
        else if (run && tick && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A zero count is a reserved value: it never reaches the expiry point
    assign expire = run && tick && (cnt_q == W'(1));

    AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/nprt_regs.sv
module nprt_regs #(
    parameter int               REG_W   = 32,
    parameter int               CPL_W   = 24,
    parameter int               RTY_W   = 28,
    parameter logic [REG_W-1:0] CPL_RST = 32'h0010_FFFF,
    parameter logic [REG_W-1:0] RTY_RST = 32'h0400_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             cpl_dis,
    output logic [CPL_W-1:0] cpl_cnt,
    output logic             rty_dis,
    output logic [RTY_W-1:0] rty_cnt
);
    typedef struct packed {
        logic             cpl_dis;
        logic [CPL_W-1:0] cpl_cnt;
        logic             rty_dis;
        logic [RTY_W-1:0] rty_cnt;
    } regs_t;

    localparam regs_t RST_VAL = '{
        cpl_dis: CPL_RST[REG_W-1],
        cpl_cnt: CPL_RST[CPL_W-1:0],
        rty_dis: RTY_RST[REG_W-1],
        rty_cnt: RTY_RST[RTY_W-1:0]
    };

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            if (sel) begin
                regs_d.rty_dis = wdata[REG_W-1];
                regs_d.rty_cnt = wdata[RTY_W-1:0];
            end else begin
                regs_d.cpl_dis = wdata[REG_W-1];
                regs_d.cpl_cnt = wdata[CPL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[RTY_W-1:0] = regs_q.rty_cnt;
            rdata[REG_W-1]   = regs_q.rty_dis;
        end else begin
            rdata[CPL_W-1:0] = regs_q.cpl_cnt;
            rdata[REG_W-1]   = regs_q.cpl_dis;
        end
    end

    assign cpl_dis = regs_q.cpl_dis;
    assign cpl_cnt = regs_q.cpl_cnt;
    assign rty_dis = regs_q.rty_dis;
    assign rty_cnt = regs_q.rty_cnt;

    AST_RSVD_CPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata[REG_W-2:CPL_W] == '0)); // R2
    AST_RSVD_RTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (rdata[REG_W-2:RTY_W] == '0)); // R2

endmodule

// File: rtl/npr_timeout_ctrl.sv
module npr_timeout_ctrl
    import nprt_pkg::*;
#(
    parameter int          REG_W       = 32,
    parameter int          CPL_W       = 24,
    parameter int          RTY_W       = 28,
    parameter int          TICK_DIV    = 8,
    parameter int          REISSUE_GAP = 5,
    parameter logic [31:0] CPL_RST     = 32'h0010_FFFF,
    parameter logic [31:0] RTY_RST     = 32'h0400_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_issue,
    input  logic             req_is_cfg,
    input  logic             cpl_rcvd,
    input  logic             crs_rcvd,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             busy,
    output logic             reissue,
    output logic             tmo_err,
    output logic             done,
    output logic             aborted
);
    localparam int GW = $clog2(REISSUE_GAP + 1);

    typedef struct packed {
        nprt_state_e      state;
        logic             cfg;
        logic             cpl_en;
        logic             rty_en;
        logic             rty_run;
        logic [CPL_W-1:0] cpl_snap;
        logic             done;
        logic             aborted;
        logic             err;
        logic             reissue;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tick;
    logic             cfg_cpl_dis, cfg_rty_dis;
    logic [CPL_W-1:0] cfg_cpl_cnt;
    logic [RTY_W-1:0] cfg_rty_cnt;
    logic             cpl_exp, rty_exp, gap_exp;
    logic             accept, go_gap, do_reissue, finish, fin_abort;

    nprt_presc #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    nprt_regs #(
        .REG_W   (REG_W),
        .CPL_W   (CPL_W),
        .RTY_W   (RTY_W),
        .CPL_RST (CPL_RST[REG_W-1:0]),
        .RTY_RST (RTY_RST[REG_W-1:0])
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .cpl_dis (cfg_cpl_dis),
        .cpl_cnt (cfg_cpl_cnt),
        .rty_dis (cfg_rty_dis),
        .rty_cnt (cfg_rty_cnt)
    );

    // Response timer: loaded at acceptance and again at every reissue
    nprt_tmr #(.W(CPL_W)) u_cpl_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept | do_reissue),
        .load_val (accept ? cfg_cpl_cnt : ctl_q.cpl_snap),
        .run      ((ctl_q.state == ST_WAIT) && ctl_q.cpl_en),
        .tick     (tick),
        .expire   (cpl_exp)
    );

    // Retry window: loaded at acceptance, counts once the first CRS arrives
    nprt_tmr #(.W(RTY_W)) u_rty_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_rty_cnt),
        .run      (ctl_q.rty_run),
        .tick     (tick),
        .expire   (rty_exp)
    );

    // Spacing between a CRS and the reissue it triggers
    nprt_tmr #(.W(GW)) u_gap_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_gap),
        .load_val (GW'(REISSUE_GAP)),
        .run      (ctl_q.state == ST_GAP),
        .tick     (tick),
        .expire   (gap_exp)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.aborted = 1'b0;
        ctl_d.err     = 1'b0;
        ctl_d.reissue = 1'b0;
        accept        = 1'b0;
        go_gap        = 1'b0;
        do_reissue    = 1'b0;
        finish        = 1'b0;
        fin_abort     = 1'b0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (req_issue) begin
                    accept         = 1'b1;
                    ctl_d.state    = ST_WAIT;
                    ctl_d.cfg      = req_is_cfg;
                    ctl_d.cpl_en   = !cfg_cpl_dis;
                    ctl_d.rty_en   = !cfg_rty_dis;
                    ctl_d.rty_run  = 1'b0;
                    ctl_d.cpl_snap = cfg_cpl_cnt;
                end
            end
            ST_WAIT: begin
                if (cpl_rcvd) begin
                    finish = 1'b1;
                end else if (rty_exp || cpl_exp) begin
                    finish    = 1'b1;
                    fin_abort = 1'b1;
                end else if (crs_rcvd) begin
                    if (ctl_q.cfg && ctl_q.rty_en) begin
                        go_gap        = 1'b1;
                        ctl_d.state   = ST_GAP;
                        ctl_d.rty_run = 1'b1;
                    end else begin
                        finish    = 1'b1;
                        fin_abort = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (cpl_rcvd) begin
                    finish = 1'b1;
                end else if (rty_exp) begin
                    finish    = 1'b1;
                    fin_abort = 1'b1;
                end else if (gap_exp) begin
                    do_reissue    = 1'b1;
                    ctl_d.reissue = 1'b1;
                    ctl_d.state   = ST_WAIT;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (finish) begin
            ctl_d.state   = ST_IDLE;
            ctl_d.done    = 1'b1;
            ctl_d.aborted = fin_abort;
            ctl_d.err     = fin_abort;
            ctl_d.rty_run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, cpl_snap: '0, default: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign busy    = (ctl_q.state != ST_IDLE);
    assign reissue = ctl_q.reissue;
    assign tmo_err = ctl_q.err;
    assign done    = ctl_q.done;
    assign aborted = ctl_q.aborted;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_ERR_MEANS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (done && aborted)); // R4
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
    AST_REISSUE_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        reissue |-> (ctl_q.cfg && ctl_q.rty_en)); // R9
    AST_REISSUE_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reissue |-> (busy && !done)); // R7

endmodule

// File: tb/npr_timeout_ctrl_test.sv
module npr_timeout_ctrl_test;
    localparam int DIV = 8;
    localparam int GAP = 3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_issue = 1'b0, req_is_cfg = 1'b0, cpl_rcvd = 1'b0, crs_rcvd = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, reissue, tmo_err, done, aborted;

    int checks = 0, failures = 0, ecnt = 0, cyc = 0;
    int nre = 0, re_e = 0, dn_e = 0;
    bit dn_seen = 0, dn_ab = 0, dn_er = 0, auto_crs = 0, wd = 0;

    npr_timeout_ctrl #(.TICK_DIV(DIV), .REISSUE_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_issue(req_issue), .req_is_cfg(req_is_cfg),
        .cpl_rcvd(cpl_rcvd), .crs_rcvd(crs_rcvd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .reissue(reissue),
        .tmo_err(tmo_err), .done(done), .aborted(aborted)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) ecnt <= ecnt + 1;
        cyc <= cyc + 1;
        if (cyc > 100000 && !wd) begin
            wd = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // n-th timer edge strictly after edge e (edges at multiples of DIV)
    function automatic int nth_tick(int e, int n);
        return ((e / DIV) + n) * DIV;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic nclk();
        @(negedge clk);
        req_issue = 1'b0;
        cpl_rcvd  = 1'b0;
        crs_rcvd  = 1'b0;
        reg_wr    = 1'b0;
        if (reissue) begin
            nre++;
            re_e = ecnt;
            if (auto_crs) crs_rcvd = 1'b1;
        end
        if (done) begin
            dn_seen = 1;
            dn_e    = ecnt;
            dn_ab   = aborted;
            dn_er   = tmo_err;
        end
    endtask

    task automatic wr_reg(bit sel, logic [31:0] v);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        nclk();
    endtask

    task automatic rd_reg(bit sel, output logic [31:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic issue(bit cfg, output int e0);
        req_issue = 1'b1; req_is_cfg = cfg;
        e0 = ecnt + 1;
        nclk();
    endtask

    task automatic wait_end(int exp_e, bit exp_ab, string req, string what);
        dn_seen = 0;
        while (!dn_seen && ecnt < exp_e + 2) nclk();
        chk(dn_seen && dn_e == exp_e, req, {what, " end edge"}, dn_seen ? dn_e : -1, exp_e);
        chk(dn_ab == exp_ab && dn_er == exp_ab, req, {what, " aborted/err"},
            {dn_ab, dn_er}, {exp_ab, exp_ab});
    endtask

    initial begin
        logic [31:0] v;
        int e0, e1, x;

        repeat (3) nclk();
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(0, v); chk(v == 32'h0010_FFFF, "R1", "response word", v, 32'h0010_FFFF);
        rd_reg(1, v); chk(v == 32'h0400_FFFF, "R1", "retry word", v, 32'h0400_FFFF);
        chk(!busy && !done && !tmo_err && !reissue, "R1", "idle outputs",
            {busy, done, tmo_err, reissue}, 0);

        // R2 field layout and reserved bits
        wr_reg(0, 32'hFFFF_FFFF);
        rd_reg(0, v); chk(v == 32'h80FF_FFFF, "R2", "response all-ones", v, 32'h80FF_FFFF);
        wr_reg(1, 32'hFFFF_FFFF);
        rd_reg(1, v); chk(v == 32'h8FFF_FFFF, "R2", "retry all-ones", v, 32'h8FFF_FFFF);
        wr_reg(0, 32'h7F00_0005);
        rd_reg(0, v); chk(v == 32'h0000_0005, "R2", "response reserved", v, 32'h5);
        wr_reg(1, 32'h7000_03E8);
        rd_reg(1, v); chk(v == 32'h0000_03E8, "R2", "retry reserved", v, 32'h3E8);

        // R3 R4 sweep: count x issue phase
        for (int n = 1; n <= 5; n++) begin
            for (int ph = 0; ph < DIV; ph++) begin
                wr_reg(0, n);
                repeat (ph) nclk();
                issue(0, e0);
                wait_end(nth_tick(e0, n), 1, "R3 R4", "response timeout");
            end
        end

        // R5 completion one edge early, then on the expiry edge itself
        wr_reg(0, 4);
        issue(0, e0);
        x = nth_tick(e0, 4);
        while (ecnt < x - 2) nclk();
        cpl_rcvd = 1'b1;
        wait_end(x - 1, 0, "R5", "early completion");
        issue(1, e0);
        x = nth_tick(e0, 4);
        while (ecnt < x - 1) nclk();
        cpl_rcvd = 1'b1;
        wait_end(x, 0, "R5", "completion on expiry edge");

        // R6 disabled timer and zero count
        wr_reg(0, 32'h8000_0002);
        issue(0, e0);
        dn_seen = 0;
        repeat (80) nclk();
        chk(!dn_seen && busy, "R6", "disabled still busy", {dn_seen, busy}, 2'b01);
        cpl_rcvd = 1'b1;
        wait_end(ecnt + 1, 0, "R6", "disabled completes");
        wr_reg(0, 0);
        issue(0, e0);
        dn_seen = 0;
        repeat (80) nclk();
        chk(!dn_seen && busy, "R6", "zero count still busy", {dn_seen, busy}, 2'b01);
        cpl_rcvd = 1'b1;
        wait_end(ecnt + 1, 0, "R6", "zero count completes");

        // R7 reissue timing and response-timer reload
        wr_reg(0, 2);
        wr_reg(1, 1000);
        issue(1, e0);
        crs_rcvd = 1'b1; e1 = ecnt + 1;
        nre = 0; re_e = 0;
        wait_end(nth_tick(e1, GAP + 2), 1, "R7", "timeout after reissue");
        chk(nre == 1 && re_e == nth_tick(e1, GAP), "R7", "reissue edge", re_e, nth_tick(e1, GAP));

        // R8 retry window sweep, CRS answered after every reissue
        wr_reg(0, 1000);
        for (int m = 1; m <= 10; m++) begin
            wr_reg(1, m);
            issue(1, e0);
            crs_rcvd = 1'b1; e1 = ecnt + 1;
            nre = 0; auto_crs = 1;
            wait_end(nth_tick(e1, m), 1, "R8", "retry window");
            auto_crs = 0;
            chk(nre == (m - 1) / GAP, "R7 R8", "reissue count", nre, (m - 1) / GAP);
        end

        // R8 zero retry count keeps reissuing
        wr_reg(1, 0);
        issue(1, e0);
        crs_rcvd = 1'b1;
        nre = 0; auto_crs = 1; dn_seen = 0;
        for (int i = 0; i < 600 && nre < 4; i++) nclk();
        auto_crs = 0;
        nclk();
        chk(nre >= 4 && !dn_seen && busy, "R8", "zero retry count", nre, 4);
        cpl_rcvd = 1'b1;
        wait_end(ecnt + 1, 0, "R8", "zero retry completes");

        // R9 no reissue for non-configuration or retry disabled
        wr_reg(1, 1000);
        nre = 0;
        issue(0, e0);
        crs_rcvd = 1'b1;
        wait_end(ecnt + 1, 1, "R9", "non-config CRS");
        wr_reg(1, 32'h8000_0064);
        issue(1, e0);
        crs_rcvd = 1'b1;
        wait_end(ecnt + 1, 1, "R9", "retry disabled CRS");
        repeat (40) nclk();
        chk(nre == 0 && !busy, "R9", "no reissue", nre, 0);

        // R10 write during active request
        wr_reg(1, 1000);
        wr_reg(0, 3);
        issue(0, e0);
        nclk();
        wr_reg(0, 6);
        wait_end(nth_tick(e0, 3), 1, "R10", "old count kept");
        issue(0, e0);
        wait_end(nth_tick(e0, 6), 1, "R10", "new count used");

        // R11 issue while busy ignored
        wr_reg(0, 3);
        issue(0, e0);
        repeat (5) nclk();
        req_issue = 1'b1; req_is_cfg = 1'b1;
        nclk();
        wait_end(nth_tick(e0, 3), 1, "R11", "timer not restarted");
        nclk();
        chk(!busy, "R11", "idle after end", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule